// File: doc/BRIEF.md
# Gather Descriptor Ring Engine

This block drains a circular ring of source descriptors. Each descriptor names one buffer: a 40-bit address, a byte count, a metadata word, a gather bit and a byte-swap bit. A producer first asks whether a list of N descriptors fits. It then pushes the descriptors one per cycle. Every descriptor of a list except the final one has its gather bit set.

The engine takes at most one descriptor per clock. It adds each descriptor's byte count into a running total. On the final descriptor of a chain it writes one entry into a status ring and raises a one-cycle completion event. The entry holds the chain's total byte count, the final descriptor's metadata and its swap bit. The event carries the final buffer's address. A consumer reads the status ring through a valid/pop pair. Data movement is modelled only as a byte count.

Top module: `gdr_engine_top`

## Requirements
- R1: After reset, post_ack, post_nak, sts_valid and evt_pulse are 0, and both rings are empty.
- R2: A buffer address is taken as post_addr_hi (8 bits, the upper bits) joined above post_addr_lo (32 bits). On a completion, evt_addr_hi/evt_addr_lo return the address of the chain's final descriptor.
- R3: A chain is a run of descriptors with post_gather=1, closed by one with post_gather=0. It produces exactly one status entry and exactly one one-cycle evt_pulse. sts_len is the sum of the chain's byte counts, and sts_meta is the final descriptor's metadata.
- R4: A descriptor's swap bit is cfg_swap_en AND NOT post_noswap, captured when it is pushed. sts_swapped reports the bit of the chain's final descriptor.
- R5: A post_req pulse carrying post_cnt is answered on the following cycle by exactly one of post_ack or post_nak. post_ack means post_cnt is at most the free source slots, where free slots = SRC_DEPTH-1 minus the occupied slots. With no request, both outputs stay 0.
- R6: Ring indices advance modulo the power-of-two depth, and one slot always stays empty. A source ring therefore holds SRC_DEPTH-1 descriptors, and a post_push while it is full is dropped.
- R7: A status entry whose byte count is zero is not complete. sts_valid stays 0 while it is at the head, and sts_pop has no effect then.
- R8: sts_pop with sts_valid=1 clears the head entry's byte count and retires the entry. Entries leave in the order they were written.
- R9: The engine consumes at most one descriptor per cycle. While the status ring is full it consumes nothing and keeps its running total.
- R10: A descriptor pushed at clock edge k is consumed at edge k+1. The status entry and evt_pulse of a chain become visible right after the edge that consumes its final descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_swap_en | input | 1 | Channel requests byte swapping |
| post_req | input | 1 | Ask whether a list fits |
| post_cnt | input | CNT_W | Number of descriptors in the list |
| post_ack | output | 1 | List fits (one cycle after post_req) |
| post_nak | output | 1 | List rejected (one cycle after post_req) |
| post_push | input | 1 | Write one descriptor into the source ring |
| post_addr_lo | input | 32 | Buffer address, low word |
| post_addr_hi | input | 8 | Buffer address, high field |
| post_len | input | LEN_W | Byte count |
| post_meta | input | META_W | Metadata word |
| post_gather | input | 1 | More descriptors follow in this chain |
| post_noswap | input | 1 | This send disables swapping |
| sts_valid | output | 1 | Head status entry is complete |
| sts_len | output | TOT_W | Total byte count of the head entry |
| sts_meta | output | META_W | Metadata of the head entry |
| sts_swapped | output | 1 | Swap indication of the head entry |
| sts_pop | input | 1 | Retire the head status entry |
| evt_pulse | output | 1 | One-cycle completion event |
| evt_addr_lo | output | 32 | Final buffer address of the completed chain, low word |
| evt_addr_hi | output | 8 | Final buffer address of the completed chain, high field |

## Verification
Results arrive on a fixed schedule:
- post_ack or post_nak is due one edge after the post_req edge.
- The status entry and evt_pulse of a chain are due one edge after the edge that pushes the chain's final descriptor.

The bench drives inputs and samples outputs on falling edges. It checks the outputs at the negedge just before and just after each due edge. This confirms nothing appears early and evt_pulse lasts one cycle. For the stall and zero-length cases, it waits several cycles before checking that the state held.

// File: rtl/gdr_pkg.sv
package gdr_pkg;
  parameter int ADDR_LO_W = 32;
  parameter int ADDR_HI_W = 8;
  parameter int ADDR_W    = ADDR_LO_W + ADDR_HI_W;
  parameter int LEN_W     = 16;
  parameter int META_W    = 16;
  parameter int TOT_W     = LEN_W + 4;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
    logic [META_W-1:0] meta;
    logic              gather;
    logic              swap;
  } src_desc_t;

  typedef struct packed {
    logic [TOT_W-1:0]  tot;
    logic [META_W-1:0] meta;
    logic              swapped;
  } sts_ent_t;

  localparam int SRC_W = $bits(src_desc_t);
  localparam int STS_W = $bits(sts_ent_t);

  // swap applies when the channel asks for it and the send does not veto it
  function automatic logic swap_bit(input logic cfg, input logic nosw);
    return cfg & ~nosw;
  endfunction

  function automatic logic [ADDR_W-1:0] join_addr(input logic [ADDR_LO_W-1:0] lo,
                                                  input logic [ADDR_HI_W-1:0] hi);
    return {hi, lo};
  endfunction

  function automatic logic [TOT_W-1:0] chain_sum(input logic [TOT_W-1:0] acc,
                                                 input logic [LEN_W-1:0] len);
    return acc + TOT_W'(len);
  endfunction

  // power-of-two ring: increment then mask
  function automatic int unsigned idx_adv(input int unsigned idx, input int unsigned depth);
    return (idx + 1) & (depth - 1);
  endfunction

  function automatic bit list_fits(input int unsigned free_slots, input int unsigned cnt);
    return cnt <= free_slots;
  endfunction
endpackage

// File: rtl/gdr_ring.sv
module gdr_ring #(
  parameter int W = 8,
  parameter int DEPTH = 8,
  parameter logic [W-1:0] POP_CLR = '0,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic             full,
  output logic             empty,
  output logic [IDX_W-1:0] used,
  output logic [IDX_W-1:0] rd_idx
);
  import gdr_pkg::*;

  logic [W-1:0]     mem [DEPTH];
  logic [IDX_W-1:0] wr_q, rd_q, wr_nxt, rd_nxt;

  always_comb begin
    wr_nxt = IDX_W'(idx_adv(32'(wr_q), DEPTH));
    rd_nxt = IDX_W'(idx_adv(32'(rd_q), DEPTH));
    full   = (wr_nxt == rd_q);
    empty  = (wr_q == rd_q);
    used   = wr_q - rd_q;
    dout   = mem[rd_q];
    rd_idx = rd_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push && !full) begin
        mem[wr_q] <= din;
        wr_q      <= wr_nxt;
      end
      if (pop && !empty) begin
        mem[rd_q] <= mem[rd_q] & ~POP_CLR;
        rd_q      <= rd_nxt;
      end
    end
  end
endmodule

// File: rtl/gdr_admit.sv
module gdr_admit #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [CNT_W-1:0] cnt,
  input  logic [IDX_W-1:0] used,
  output logic             ack,
  output logic             nak
);
  import gdr_pkg::*;

  int unsigned free_slots;
  logic        fits;

  always_comb begin
    free_slots = 32'(DEPTH - 1) - 32'(used);
    fits       = list_fits(free_slots, 32'(cnt));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack <= 1'b0;
      nak <= 1'b0;
    end else begin
      ack <= req & fits;
      nak <= req & ~fits;
    end
  end
endmodule

// File: rtl/gdr_chain.sv
module gdr_chain (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       src_empty,
  input  gdr_pkg::src_desc_t         head,
  input  logic                       sts_full,
  output logic                       src_pop,
  output logic                       sts_push,
  output gdr_pkg::sts_ent_t          sts_ent,
  output logic                       evt_pulse,
  output logic [gdr_pkg::ADDR_W-1:0] evt_addr,
  output logic [gdr_pkg::TOT_W-1:0]  acc
);
  import gdr_pkg::*;

  logic [TOT_W-1:0] acc_q, sum;
  logic             step;

  always_comb begin
    step            = !src_empty && !sts_full;
    sum             = chain_sum(acc_q, head.len);
    src_pop         = step;
    sts_push        = step && !head.gather;
    sts_ent.tot     = sum;
    sts_ent.meta    = head.meta;
    sts_ent.swapped = head.swap;
    acc             = acc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= '0;
      evt_pulse <= 1'b0;
      evt_addr  <= '0;
    end else begin
      if (step) acc_q <= head.gather ? sum : '0;
      evt_pulse <= sts_push;
      if (sts_push) evt_addr <= head.addr;
    end
  end
endmodule

// File: rtl/gdr_engine_top.sv
module gdr_engine_top #(
  parameter int SRC_DEPTH = 8,
  parameter int STS_DEPTH = 4,
  localparam int CNT_W = $clog2(SRC_DEPTH) + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_swap_en,
  input  logic                          post_req,
  input  logic [CNT_W-1:0]              post_cnt,
  output logic                          post_ack,
  output logic                          post_nak,
  input  logic                          post_push,
  input  logic [gdr_pkg::ADDR_LO_W-1:0] post_addr_lo,
  input  logic [gdr_pkg::ADDR_HI_W-1:0] post_addr_hi,
  input  logic [gdr_pkg::LEN_W-1:0]     post_len,
  input  logic [gdr_pkg::META_W-1:0]    post_meta,
  input  logic                          post_gather,
  input  logic                          post_noswap,
  output logic                          sts_valid,
  output logic [gdr_pkg::TOT_W-1:0]     sts_len,
  output logic [gdr_pkg::META_W-1:0]    sts_meta,
  output logic                          sts_swapped,
  input  logic                          sts_pop,
  output logic                          evt_pulse,
  output logic [gdr_pkg::ADDR_LO_W-1:0] evt_addr_lo,
  output logic [gdr_pkg::ADDR_HI_W-1:0] evt_addr_hi
);
  import gdr_pkg::*;

  localparam int SRC_IDX_W = $clog2(SRC_DEPTH);
  localparam int STS_IDX_W = $clog2(STS_DEPTH);
  localparam logic [STS_W-1:0] STS_CLR = {{TOT_W{1'b1}}, {(META_W + 1){1'b0}}};

  src_desc_t             src_din, src_head;
  sts_ent_t              sts_din, sts_head;
  logic [SRC_W-1:0]      src_head_raw;
  logic [STS_W-1:0]      sts_head_raw;
  logic                  src_full_w, src_empty_w, src_pop_w;
  logic                  sts_full_w, sts_empty_w, sts_push_w, sts_pop_ok;
  logic [SRC_IDX_W-1:0]  src_used_w, src_rd_w;
  logic [STS_IDX_W-1:0]  sts_used_w, sts_rd_w;
  logic [ADDR_W-1:0]     evt_addr_w;
  logic [TOT_W-1:0]      acc_w;

  always_comb begin
    src_din.addr   = join_addr(post_addr_lo, post_addr_hi);
    src_din.len    = post_len;
    src_din.meta   = post_meta;
    src_din.gather = post_gather;
    src_din.swap   = swap_bit(cfg_swap_en, post_noswap);
    src_head       = src_desc_t'(src_head_raw);
    sts_head       = sts_ent_t'(sts_head_raw);
    sts_valid      = !sts_empty_w && (sts_head.tot != '0);
    sts_pop_ok     = sts_pop && sts_valid;
    sts_len        = sts_head.tot;
    sts_meta       = sts_head.meta;
    sts_swapped    = sts_head.swapped;
    evt_addr_lo    = evt_addr_w[ADDR_LO_W-1:0];
    evt_addr_hi    = evt_addr_w[ADDR_W-1:ADDR_LO_W];
  end

  gdr_admit #(.DEPTH(SRC_DEPTH), .CNT_W(CNT_W)) admit_i (
    .clk(clk), .rst_n(rst_n), .req(post_req), .cnt(post_cnt),
    .used(src_used_w), .ack(post_ack), .nak(post_nak)
  );

  gdr_ring #(.W(SRC_W), .DEPTH(SRC_DEPTH)) src_ring_i (
    .clk(clk), .rst_n(rst_n), .push(post_push), .din(src_din),
    .pop(src_pop_w), .dout(src_head_raw), .full(src_full_w),
    .empty(src_empty_w), .used(src_used_w), .rd_idx(src_rd_w)
  );

  gdr_chain chain_i (
    .clk(clk), .rst_n(rst_n), .src_empty(src_empty_w), .head(src_head),
    .sts_full(sts_full_w), .src_pop(src_pop_w), .sts_push(sts_push_w),
    .sts_ent(sts_din), .evt_pulse(evt_pulse), .evt_addr(evt_addr_w),
    .acc(acc_w)
  );

  gdr_ring #(.W(STS_W), .DEPTH(STS_DEPTH), .POP_CLR(STS_CLR)) sts_ring_i (
    .clk(clk), .rst_n(rst_n), .push(sts_push_w), .din(sts_din),
    .pop(sts_pop_ok), .dout(sts_head_raw), .full(sts_full_w),
    .empty(sts_empty_w), .used(sts_used_w), .rd_idx(sts_rd_w)
  );
endmodule

// File: rtl/gdr_chk.sv
module gdr_chk #(
  parameter int SRC_DEPTH = 8,
  parameter int STS_DEPTH = 4,
  localparam int SRC_IDX_W = $clog2(SRC_DEPTH),
  localparam int STS_IDX_W = $clog2(STS_DEPTH)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        post_req,
  input logic                        post_ack,
  input logic                        post_nak,
  input logic                        sts_push_w,
  input logic                        evt_pulse,
  input logic                        sts_full_w,
  input logic [SRC_IDX_W-1:0]        src_rd_w,
  input logic [gdr_pkg::TOT_W-1:0]   acc_w,
  input logic                        sts_pop,
  input logic                        sts_valid,
  input logic [STS_IDX_W-1:0]        sts_used_w
);
  AST_ADMIT_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    post_req |=> (post_ack ^ post_nak)); // R5
  AST_ADMIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !post_req |=> (!post_ack && !post_nak)); // R5
  AST_EVT_AFTER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    sts_push_w |=> evt_pulse); // R3
  AST_EVT_ONLY_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_push_w |=> !evt_pulse); // R3
  AST_TOTAL_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    sts_push_w |=> (acc_w == '0)); // R3
  AST_HOLD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    sts_full_w |=> ($stable(src_rd_w) && $stable(acc_w))); // R9
  AST_INCOMPLETE_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_pop && !sts_valid && !sts_push_w) |=> $stable(sts_used_w)); // R7
endmodule

bind gdr_engine_top gdr_chk #(.SRC_DEPTH(SRC_DEPTH), .STS_DEPTH(STS_DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .post_req(post_req), .post_ack(post_ack),
  .post_nak(post_nak), .sts_push_w(sts_push_w), .evt_pulse(evt_pulse),
  .sts_full_w(sts_full_w), .src_rd_w(src_rd_w), .acc_w(acc_w),
  .sts_pop(sts_pop), .sts_valid(sts_valid), .sts_used_w(sts_used_w)
);

// File: tb/gdr_engine_top_tb_top.sv
`timescale 1ns/1ps
module gdr_engine_top_tb_top;
  import gdr_pkg::*;

  localparam int SRC_DEPTH = 8;
  localparam int STS_DEPTH = 4;
  localparam int CNT_W = $clog2(SRC_DEPTH) + 1;

  typedef struct packed {
    logic [3:0]  n;
    logic [15:0] base;
    logic [15:0] meta;
    logic        noswap;
    logic        cfg;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'd1, 16'd100,    16'h0011, 1'b0, 1'b1},
    '{4'd2, 16'd50,     16'h0022, 1'b0, 1'b1},
    '{4'd3, 16'd7,      16'h0033, 1'b1, 1'b1},
    '{4'd5, 16'd1000,   16'h0044, 1'b0, 1'b0},
    '{4'd7, 16'hFFF0,   16'h0055, 1'b0, 1'b1},
    '{4'd4, 16'd3,      16'h0066, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_swap_en = 1'b0, post_req = 1'b0, post_push = 1'b0;
  logic [CNT_W-1:0] post_cnt = '0;
  logic post_ack, post_nak;
  logic [ADDR_LO_W-1:0] post_addr_lo = '0;
  logic [ADDR_HI_W-1:0] post_addr_hi = '0;
  logic [LEN_W-1:0] post_len = '0;
  logic [META_W-1:0] post_meta = '0;
  logic post_gather = 1'b0, post_noswap = 1'b0;
  logic sts_valid, sts_swapped, sts_pop = 1'b0, evt_pulse;
  logic [TOT_W-1:0] sts_len;
  logic [META_W-1:0] sts_meta;
  logic [ADDR_LO_W-1:0] evt_addr_lo;
  logic [ADDR_HI_W-1:0] evt_addr_hi;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  gdr_engine_top #(.SRC_DEPTH(SRC_DEPTH), .STS_DEPTH(STS_DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_swap_en(cfg_swap_en),
    .post_req(post_req), .post_cnt(post_cnt), .post_ack(post_ack), .post_nak(post_nak),
    .post_push(post_push), .post_addr_lo(post_addr_lo), .post_addr_hi(post_addr_hi),
    .post_len(post_len), .post_meta(post_meta), .post_gather(post_gather),
    .post_noswap(post_noswap), .sts_valid(sts_valid), .sts_len(sts_len),
    .sts_meta(sts_meta), .sts_swapped(sts_swapped), .sts_pop(sts_pop),
    .evt_pulse(evt_pulse), .evt_addr_lo(evt_addr_lo), .evt_addr_hi(evt_addr_hi)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic ask(input int cnt);
    post_req = 1'b1; post_cnt = CNT_W'(cnt);
    @(negedge clk) post_req = 1'b0;
  endtask

  task automatic push_one(input logic [31:0] lo, input logic [7:0] hi, input logic [15:0] len,
                          input logic [15:0] meta, input logic gth, input logic nsw);
    post_push = 1'b1; post_addr_lo = lo; post_addr_hi = hi; post_len = len;
    post_meta = meta; post_gather = gth; post_noswap = nsw;
    @(negedge clk) post_push = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    logic [TOT_W-1:0] sum = '0;
    logic [31:0] lo_last = '0;
    cfg_swap_en = v.cfg;
    ask(int'(v.n));
    chk("R5 list fits, ack", {63'd0, post_ack}, 64'd1);
    for (int i = 0; i < int'(v.n); i++) begin
      post_push = 1'b1;
      post_addr_lo = 32'hA000_0000 + 32'(v.base) + 32'(i);
      post_addr_hi = v.meta[7:0] ^ 8'h5A;
      post_len = v.base + 16'(i);
      post_meta = (i == int'(v.n) - 1) ? v.meta : 16'hDEAD;
      post_gather = (i != int'(v.n) - 1);
      post_noswap = v.noswap;
      sum = sum + TOT_W'(post_len);
      lo_last = post_addr_lo;
      @(negedge clk);
    end
    post_push = 1'b0;
    chk("R10 no early completion", {62'd0, evt_pulse, sts_valid}, 64'd0);
    @(negedge clk);
    chk("R3 event pulse", {63'd0, evt_pulse}, 64'd1);
    chk("R3 one status entry", {63'd0, sts_valid}, 64'd1);
    chk("R3 total length", 64'(sts_len), 64'(sum));
    chk("R3 final metadata", 64'(sts_meta), 64'(v.meta));
    chk("R4 swap indication", {63'd0, sts_swapped}, {63'd0, v.cfg & ~v.noswap});
    chk("R2 address low", 64'(evt_addr_lo), 64'(lo_last));
    chk("R2 address high", 64'(evt_addr_hi), 64'(v.meta[7:0] ^ 8'h5A));
    @(negedge clk);
    chk("R3 event lasts one cycle", {63'd0, evt_pulse}, 64'd0);
    sts_pop = 1'b1;
    @(negedge clk) sts_pop = 1'b0;
    chk("R8 entry retired", {63'd0, sts_valid}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] exp_q [10];
    do_reset();
    @(negedge clk);
    chk("R1 reset outputs", {60'd0, post_ack, post_nak, sts_valid, evt_pulse}, 64'd0);

    foreach (VECS[k]) run_vec(VECS[k]);

    ask(SRC_DEPTH);
    chk("R5 R6 list larger than capacity rejected", {62'd0, post_ack, post_nak}, 64'd1);
    ask(SRC_DEPTH - 1);
    chk("R6 capacity is depth minus one", {62'd0, post_ack, post_nak}, 64'd2);

    // fill status ring, then stall engine with full source ring
    cfg_swap_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      push_one(32'h10 + 32'(i), 8'h1, 16'd10 + 16'(i), 16'h0100, 1'b0, 1'b0);
      @(negedge clk);
    end
    for (int i = 0; i < SRC_DEPTH; i++)
      push_one(32'h20 + 32'(i), 8'h2, 16'd20 + 16'(i), 16'h0200, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    ask(1);
    chk("R9 engine held while status full", {62'd0, post_ack, post_nak}, 64'd1);
    for (int i = 0; i < 3; i++) exp_q[i] = 16'd10 + 16'(i);
    for (int i = 0; i < 7; i++) exp_q[3 + i] = 16'd20 + 16'(i);
    for (int i = 0; i < 10; i++) begin
      chk("R8 R9 entry in order", {47'd0, sts_valid, 16'(sts_len)}, {47'd0, 1'b1, exp_q[i]});
      sts_pop = 1'b1;
      @(negedge clk) sts_pop = 1'b0;
      repeat (3) @(negedge clk);
    end
    chk("R6 push into full ring dropped", {63'd0, sts_valid}, 64'd0);

    // zero-length entry is never complete
    push_one(32'h30, 8'h3, 16'd0, 16'h0300, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R7 zero length not valid", {63'd0, sts_valid}, 64'd0);
    sts_pop = 1'b1;
    @(negedge clk) sts_pop = 1'b0;
    push_one(32'h31, 8'h3, 16'd9, 16'h0301, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R7 pop on incomplete head ignored", {63'd0, sts_valid}, 64'd0);

    do_reset();
    @(negedge clk);
    chk("R1 reset clears rings", {60'd0, post_ack, post_nak, sts_valid, evt_pulse}, 64'd0);
    ask(SRC_DEPTH - 1);
    chk("R1 source ring empty after reset", {62'd0, post_ack, post_nak}, 64'd2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule